// File: doc/BRIEF.md
# Retention Failure Recovery Classifier

This block repairs the cells of a flash page whose normal read failed error correction. Each cell arrives with two quantized threshold-voltage codes: one from a recent sensing and one from an earlier sensing of the same cell. Cells whose present code lies near the tuned boundary between the two highest programmed states are treated as doubtful. For those cells the block does not trust the voltage alone. It decides the original state from how quickly the cell has been losing charge.

A cell that leaks fast has sagged from the higher state. A cell that leaks slowly was programmed to the lower state. Every other cell keeps the plain hard decision from the three read boundaries. The block streams out the corrected 2-bit values so a downstream decoder can try again. With the last cell of each page it reports how many cells were doubtful and how many had their value changed.

Cells move one per clock under a valid/ready handshake. An output register gives one cycle of latency.

Top module: `rfr_classifier`

## Requirements
- R1: A cell outside the doubtful window gets the hard decision from its present code `v`. If v < cfg_ref_er_p1 the output is 11 (erased). Otherwise, if v < cfg_ref_p1_p2 the output is 10 (P1). Otherwise, if v < cfg_ref_opt the output is 00 (P2). Otherwise the output is 01 (P3).
- R2: A cell is doubtful when cfg_ref_opt − cfg_sigma ≤ v ≤ cfg_ref_opt + cfg_sigma. Both ends are inclusive, and both bounds are computed without wrap-around (the low bound stops at 0 and the high bound may exceed the code range). m_risky reports the result.
- R3: The leak amount is the earlier code minus the present code, or 0 when the present code is not lower. A cell counts as fast only when the leak amount is strictly greater than cfg_leak_thr.
- R4: A doubtful cell that is not fast is output as 00 (P2), whatever its hard decision would be.
- R5: A doubtful fast cell is output as 01 (P3), whatever its hard decision would be.
- R6: While m_valid is high and m_ready is low, m_state, m_risky and m_last hold steady and s_ready is low.
- R7: On the output beat carrying m_last=1, m_page_risky equals the number of doubtful cells in that page and m_page_fixed equals the number of doubtful cells whose output differs from their hard decision. Both counts include the last cell, and counting restarts from zero for the next page.
- R8: After reset, m_valid is low and s_ready is high.
- R9: A cell accepted on a clock edge is presented on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ref_er_p1 | input | VTH_W | Boundary between erased and P1 |
| cfg_ref_p1_p2 | input | VTH_W | Boundary between P1 and P2 |
| cfg_ref_opt | input | VTH_W | Tuned P2/P3 boundary |
| cfg_sigma | input | VTH_W | Half-width of the doubtful window |
| cfg_leak_thr | input | VTH_W | Leak amount that must be exceeded to count as fast |
| s_valid | input | 1 | Input cell valid |
| s_ready | output | 1 | Block can take a cell |
| s_vth_now | input | VTH_W | Present threshold code |
| s_vth_early | input | VTH_W | Earlier threshold code of the same cell |
| s_last | input | 1 | Last cell of the page |
| m_valid | output | 1 | Output cell valid |
| m_ready | input | 1 | Consumer takes the output |
| m_state | output | 2 | Corrected cell value |
| m_risky | output | 1 | Cell was in the doubtful window |
| m_last | output | 1 | Last cell of the page |
| m_page_risky | output | CNT_W | Doubtful cells in the page (meaningful with m_last) |
| m_page_fixed | output | CNT_W | Changed cells in the page (meaningful with m_last) |

## Verification
The hardest case to reach from the ports is a held output beat that must not be lost while the next cell waits at the input. The stimulus drops m_ready just after one cell has been accepted and keeps offering a second cell. The bench confirms the first cell stays unchanged and s_ready stays low, then releases the consumer and checks that the second cell arrives on the next beat. Window edges and the leak threshold are hit at exactly the boundary value and one step beyond it, and page counts are checked across two consecutive pages.

// File: rtl/rfr_pkg.sv
package rfr_pkg;
    typedef enum logic [1:0] {
        ST_ERASED = 2'b11,
        ST_P1     = 2'b10,
        ST_P2     = 2'b00,
        ST_P3     = 2'b01
    } cell_state_e;
endpackage

// File: rtl/rfr_window.sv
module rfr_window
    import rfr_pkg::*;
#(
    parameter int VTH_W = 8
) (
    input  logic [VTH_W-1:0] vth,
    input  logic [VTH_W-1:0] ref_er_p1,
    input  logic [VTH_W-1:0] ref_p1_p2,
    input  logic [VTH_W-1:0] ref_opt,
    input  logic [VTH_W-1:0] sigma,
    output cell_state_e      hard_state,
    output logic             risky
);
    localparam int EXT_W = VTH_W + 1;

    logic [EXT_W-1:0] lo_bound;
    logic [EXT_W-1:0] hi_bound;

    always_comb begin
        // low bound clamps at zero, high bound uses one extra bit
        lo_bound = (ref_opt > sigma) ? {1'b0, ref_opt - sigma} : '0;
        hi_bound = {1'b0, ref_opt} + {1'b0, sigma};
        risky    = ({1'b0, vth} >= lo_bound) && ({1'b0, vth} <= hi_bound);

        if (vth < ref_er_p1) begin
            hard_state = ST_ERASED;
        end else if (vth < ref_p1_p2) begin
            hard_state = ST_P1;
        end else if (vth < ref_opt) begin
            hard_state = ST_P2;
        end else begin
            hard_state = ST_P3;
        end
    end
endmodule

// File: rtl/rfr_leak.sv
module rfr_leak #(
    parameter int VTH_W = 8
) (
    input  logic [VTH_W-1:0] vth_now,
    input  logic [VTH_W-1:0] vth_early,
    input  logic [VTH_W-1:0] leak_thr,
    output logic             fast
);
    logic [VTH_W-1:0] drop;

    always_comb begin
        drop = (vth_early > vth_now) ? (vth_early - vth_now) : '0;
        fast = drop > leak_thr;
    end
endmodule

// File: rtl/rfr_assign.sv
module rfr_assign
    import rfr_pkg::*;
(
    input  cell_state_e hard_state,
    input  logic        risky,
    input  logic        fast,
    output cell_state_e final_state,
    output logic        changed
);
    always_comb begin
        if (risky) begin
            final_state = fast ? ST_P3 : ST_P2;
        end else begin
            final_state = hard_state;
        end
        changed = risky && (final_state != hard_state);
    end
endmodule

// File: rtl/rfr_classifier.sv
module rfr_classifier
    import rfr_pkg::*;
#(
    parameter int VTH_W = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VTH_W-1:0] cfg_ref_er_p1,
    input  logic [VTH_W-1:0] cfg_ref_p1_p2,
    input  logic [VTH_W-1:0] cfg_ref_opt,
    input  logic [VTH_W-1:0] cfg_sigma,
    input  logic [VTH_W-1:0] cfg_leak_thr,
    input  logic             s_valid,
    output logic             s_ready,
    input  logic [VTH_W-1:0] s_vth_now,
    input  logic [VTH_W-1:0] s_vth_early,
    input  logic             s_last,
    output logic             m_valid,
    input  logic             m_ready,
    output logic [1:0]       m_state,
    output logic             m_risky,
    output logic             m_last,
    output logic [CNT_W-1:0] m_page_risky,
    output logic [CNT_W-1:0] m_page_fixed
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             valid;
        cell_state_e      state;
        logic             risky;
        logic             last;
        logic [CNT_W-1:0] cnt_risky;
        logic [CNT_W-1:0] cnt_fixed;
        logic [CNT_W-1:0] pg_risky;
        logic [CNT_W-1:0] pg_fixed;
    } regs_t;

    regs_t       r_d, r_q;
    cell_state_e hard_state;
    cell_state_e final_state;
    logic        risky;
    logic        fast;
    logic        changed;
    logic        accept;
    logic [CNT_W-1:0] risky_sum;
    logic [CNT_W-1:0] fixed_sum;

    // step 1: doubtful window and hard decision
    rfr_window #(.VTH_W(VTH_W)) u_window (
        .vth        (s_vth_now),
        .ref_er_p1  (cfg_ref_er_p1),
        .ref_p1_p2  (cfg_ref_p1_p2),
        .ref_opt    (cfg_ref_opt),
        .sigma      (cfg_sigma),
        .hard_state (hard_state),
        .risky      (risky)
    );

    // step 2: leak speed
    rfr_leak #(.VTH_W(VTH_W)) u_leak (
        .vth_now   (s_vth_now),
        .vth_early (s_vth_early),
        .leak_thr  (cfg_leak_thr),
        .fast      (fast)
    );

    // step 3: state guess
    rfr_assign u_assign (
        .hard_state  (hard_state),
        .risky       (risky),
        .fast        (fast),
        .final_state (final_state),
        .changed     (changed)
    );

    assign s_ready = !r_q.valid || m_ready;
    assign accept  = s_valid && s_ready;

    always_comb begin
        r_d = r_q;
        risky_sum = (risky && r_q.cnt_risky != CNT_MAX) ? r_q.cnt_risky + 1'b1 : r_q.cnt_risky;
        fixed_sum = (changed && r_q.cnt_fixed != CNT_MAX) ? r_q.cnt_fixed + 1'b1 : r_q.cnt_fixed;
        if (r_q.valid && m_ready) begin
            r_d.valid = 1'b0;
        end
        if (accept) begin
            r_d.valid = 1'b1;
            r_d.state = final_state;
            r_d.risky = risky;
            r_d.last  = s_last;
            if (s_last) begin
                r_d.pg_risky  = risky_sum;
                r_d.pg_fixed  = fixed_sum;
                r_d.cnt_risky = '0;
                r_d.cnt_fixed = '0;
            end else begin
                r_d.cnt_risky = risky_sum;
                r_d.cnt_fixed = fixed_sum;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{valid: 1'b0, state: ST_ERASED, risky: 1'b0, last: 1'b0,
                     cnt_risky: '0, cnt_fixed: '0, pg_risky: '0, pg_fixed: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign m_valid      = r_q.valid;
    assign m_state      = r_q.state;
    assign m_risky      = r_q.risky;
    assign m_last       = r_q.last;
    assign m_page_risky = (r_q.valid && r_q.last) ? r_q.pg_risky : '0;
    assign m_page_fixed = (r_q.valid && r_q.last) ? r_q.pg_fixed : '0;

    a_r6_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_state) && $stable(m_risky) && $stable(m_last)));

    a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> m_valid);

    a_r4_r5_risky_upper_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_risky) |-> (m_state == 2'b00 || m_state == 2'b01));

    a_r7_fixed_within_risky: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_last) |-> (m_page_fixed <= m_page_risky));
endmodule

// File: tb/test_rfr_classifier.sv
module test_rfr_classifier;
    localparam int VTH_W = 8;
    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [VTH_W-1:0] cfg_ref_er_p1 = 8'd40;
    logic [VTH_W-1:0] cfg_ref_p1_p2 = 8'd100;
    logic [VTH_W-1:0] cfg_ref_opt   = 8'd160;
    logic [VTH_W-1:0] cfg_sigma     = 8'd10;
    logic [VTH_W-1:0] cfg_leak_thr  = 8'd8;
    logic s_valid = 1'b0;
    logic s_ready;
    logic [VTH_W-1:0] s_vth_now = '0;
    logic [VTH_W-1:0] s_vth_early = '0;
    logic s_last = 1'b0;
    logic m_valid;
    logic m_ready = 1'b1;
    logic [1:0] m_state;
    logic m_risky;
    logic m_last;
    logic [CNT_W-1:0] m_page_risky;
    logic [CNT_W-1:0] m_page_fixed;

    int n_checks = 0;
    int n_fail = 0;
    int pg_risky = 0;
    int pg_fixed = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    rfr_classifier #(.VTH_W(VTH_W), .CNT_W(CNT_W)) i_rfr_classifier (
        .clk(clk), .rst_n(rst_n),
        .cfg_ref_er_p1(cfg_ref_er_p1), .cfg_ref_p1_p2(cfg_ref_p1_p2),
        .cfg_ref_opt(cfg_ref_opt), .cfg_sigma(cfg_sigma), .cfg_leak_thr(cfg_leak_thr),
        .s_valid(s_valid), .s_ready(s_ready), .s_vth_now(s_vth_now),
        .s_vth_early(s_vth_early), .s_last(s_last),
        .m_valid(m_valid), .m_ready(m_ready), .m_state(m_state), .m_risky(m_risky),
        .m_last(m_last), .m_page_risky(m_page_risky), .m_page_fixed(m_page_fixed)
    );

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // independent reference of the recovery rule
    task automatic model(input int now, input int early, output int st, output int rk, output int ch);
        int hard, lo, hi, drop;
        if (now < cfg_ref_er_p1) hard = 3;
        else if (now < cfg_ref_p1_p2) hard = 2;
        else if (now < cfg_ref_opt) hard = 0;
        else hard = 1;
        lo = int'(cfg_ref_opt) - int'(cfg_sigma);
        hi = int'(cfg_ref_opt) + int'(cfg_sigma);
        rk = (now >= lo && now <= hi) ? 1 : 0;
        drop = (early > now) ? early - now : 0;
        if (rk == 1) st = (drop > cfg_leak_thr) ? 1 : 0;
        else st = hard;
        ch = (rk == 1 && st != hard) ? 1 : 0;
    endtask

    // one cell, consumer ready; checks value, window flag and page counts
    task automatic send_cell(string req, int now, int early, bit last);
        int st, rk, ch;
        model(now, early, st, rk, ch);
        pg_risky += rk;
        pg_fixed += ch;
        @(negedge clk);
        s_valid = 1'b1; s_vth_now = now[VTH_W-1:0]; s_vth_early = early[VTH_W-1:0]; s_last = last;
        @(negedge clk);
        s_valid = 1'b0;
        check({req, " R9 valid"}, int'(m_valid), 1);
        check({req, " state"}, int'(m_state), st);
        check({req, " R2 risky"}, int'(m_risky), rk);
        if (last) begin
            check("R7 page risky", int'(m_page_risky), pg_risky);
            check("R7 page fixed", int'(m_page_fixed), pg_fixed);
            pg_risky = 0;
            pg_fixed = 0;
        end
    endtask

    task automatic test_reset();
        check("R8 m_valid after reset", int'(m_valid), 0);
        check("R8 s_ready after reset", int'(s_ready), 1);
    endtask

    task automatic test_hard_regions();
        send_cell("R1 erased", 10, 10, 1'b0);
        send_cell("R1 P1", 60, 60, 1'b0);
        send_cell("R1 P2", 120, 120, 1'b0);
        send_cell("R1 P3", 200, 200, 1'b1);
    endtask

    task automatic test_window_edges();
        send_cell("R2 low edge in", 150, 150, 1'b0);
        send_cell("R2 below low edge R1", 149, 149, 1'b0);
        send_cell("R2 high edge in", 170, 170, 1'b0);
        send_cell("R2 above high edge R1", 171, 171, 1'b1);
    endtask

    task automatic test_leak();
        send_cell("R3 drop equal thr R4", 155, 163, 1'b0);
        send_cell("R3 drop above thr R5", 155, 164, 1'b0);
        send_cell("R4 slow above boundary", 165, 165, 1'b0);
        send_cell("R3 rising code R4", 165, 100, 1'b1);
    endtask

    task automatic test_second_page();
        send_cell("R7 clean page a", 20, 20, 1'b0);
        send_cell("R7 clean page b", 80, 80, 1'b1);
    endtask

    task automatic test_clamped_window();
        cfg_ref_er_p1 = 8'd1; cfg_ref_p1_p2 = 8'd3; cfg_ref_opt = 8'd5;
        send_cell("R2 low clamp", 0, 30, 1'b0);
        cfg_ref_er_p1 = 8'd40; cfg_ref_p1_p2 = 8'd100; cfg_ref_opt = 8'd250;
        send_cell("R2 high beyond range", 255, 255, 1'b1);
        cfg_ref_opt = 8'd160;
    endtask

    task automatic test_backpressure();
        int st_a, rk_a, ch_a, st_b, rk_b, ch_b;
        model(165, 190, st_a, rk_a, ch_a);
        model(60, 60, st_b, rk_b, ch_b);
        @(negedge clk);
        m_ready = 1'b0;
        s_valid = 1'b1; s_vth_now = 8'd165; s_vth_early = 8'd190; s_last = 1'b0;
        @(negedge clk);
        s_vth_now = 8'd60; s_vth_early = 8'd60; s_last = 1'b1;
        check("R6 s_ready low while held", int'(s_ready), 0);
        check("R6 first cell shown", int'(m_state), st_a);
        @(negedge clk);
        check("R6 first cell held", int'(m_state), st_a);
        check("R6 held valid", int'(m_valid), 1);
        check("R6 held last", int'(m_last), 0);
        m_ready = 1'b1;
        @(negedge clk);
        s_valid = 1'b0;
        check("R6 second cell state", int'(m_state), st_b);
        check("R7 page risky after stall", int'(m_page_risky), rk_a + rk_b);
        check("R7 page fixed after stall", int'(m_page_fixed), ch_a + ch_b);
        @(negedge clk);
        check("R9 drained", int'(m_valid), 0);
    endtask

    initial begin
        while (cycles < 5000) begin
            @(posedge clk);
            cycles++;
        end
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_hard_regions();
        test_window_edges();
        test_leak();
        test_second_page();
        test_clamped_window();
        test_backpressure();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule